// File: doc/BRIEF.md
# Priority Intersection Signal Controller

This block sequences the lamps of a two-road crossing where one road carries most of the traffic. The major road (north-south) and the minor road (east-west) each get a red, a yellow and a green lamp output. The controller steps through four phases in a fixed ring: major go, major caution, minor go, minor caution, and then back to major go. Whenever one road is in go or caution, the other road shows red.

All phase durations are counted in pulses of a tick enable input, so the same logic can serve any time base. The major road keeps its green until one of two things happens first: a long limit runs out, or a shorter minimum has passed while a car waits on the minor road. The minor green always runs for its own fixed length. Both caution phases share one yellow length. Car-presence inputs must already be clean and synchronous. The major-road presence input is accepted but does not steer any transition.

Top module: `junction_signal_ctrl`

## Requirements
- R1: While reset is asserted and right after it is released, the major road shows green and the minor road shows red. All interval counts start from zero, so with no minor car the first major green lasts exactly P_MAJ_LONG ticks.
- R2: Phases only advance in the ring major go, major caution, minor go, minor caution, major go. No phase is skipped or repeated out of order.
- R3: If no minor car is present, major green ends on the clock edge after the tick that brings its elapsed count to P_MAJ_LONG.
- R4: Major green ends early at the first edge where at least P_MAJ_MIN ticks have elapsed in the phase and minor_car is high. A minor car seen before P_MAJ_MIN ticks have elapsed does not end the phase, and a car that has gone away again has no effect.
- R5: Minor green lasts P_MIN_GO ticks whatever the car inputs do.
- R6: Each caution phase lasts P_CAUTION ticks. At its end, its road turns red and the other road turns green.
- R7: In every cycle exactly one lamp per road is lit. When either road is not red, the other road is red.
- R8: Elapsed time advances only on cycles where tick_en is high. Cycles with tick_en low leave every interval unchanged.
- R9: major_car has no effect on the lamp outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tick_en | input | 1 | Time base pulse; one pulse is one duration unit |
| major_car | input | 1 | Clean presence flag for the major road (no effect) |
| minor_car | input | 1 | Clean presence flag for the minor road |
| maj_red | output | 1 | Major road red lamp |
| maj_yel | output | 1 | Major road yellow lamp |
| maj_grn | output | 1 | Major road green lamp |
| min_red | output | 1 | Minor road red lamp |
| min_yel | output | 1 | Minor road yellow lamp |
| min_grn | output | 1 | Minor road green lamp |

## Verification
The assertions take three things for granted. The car flags and tick_en must change only between clock edges. The flags must be synchronous and free of bounce. The duration parameters must satisfy minimum below long, with every duration at least one. Under those conditions the exit rules can be checked on the timer outputs alone. The stimulus changes every input one time unit after a rising edge, and it holds the default durations with the minimum well under the long limit. It drives minor-car pulses that fall before the minimum, inside the window and after it. It also runs sparse and random tick patterns, toggles major_car freely, and applies one reset partway through a cycle.

// File: rtl/junction_pkg.sv
package junction_pkg;

  typedef enum logic [1:0] {
    PH_MAJ_GO      = 2'd0,
    PH_MAJ_CAUTION = 2'd1,
    PH_MIN_GO      = 2'd2,
    PH_MIN_CAUTION = 2'd3
  } phase_e;

  typedef struct packed {
    logic red;
    logic yel;
    logic grn;
  } lamp_t;

  localparam int unsigned NUM_TIMERS = 4;
  localparam int unsigned TMR_LONG   = 0;
  localparam int unsigned TMR_MIN    = 1;
  localparam int unsigned TMR_MINGO  = 2;
  localparam int unsigned TMR_YEL    = 3;

endpackage

// File: rtl/junction_interval_timer.sv
module junction_interval_timer #(
  parameter int unsigned LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic run,
  input  logic clr,
  output logic done
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM_V = CW'(LIMIT);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          adv;

  assign adv = run && tick_en && (cnt_q != LIM_V);

  always_comb begin
    cnt_d = cnt_q;
    if (clr || !run) begin
      cnt_d = '0;
    end else if (adv) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign done = (cnt_q == LIM_V);

  assert_cnt_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIM_V);

  assert_clear_restarts_R1: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));

  assert_idle_tick_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !clr && !tick_en) |=> $stable(cnt_q));

endmodule

// File: rtl/junction_phase_seq.sv
module junction_phase_seq
  import junction_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   minor_car,
  input  logic   long_done,
  input  logic   min_done,
  input  logic   mingo_done,
  input  logic   yel_done,
  output phase_e phase_q,
  output logic   leave
);
  phase_e phase_d;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_MAJ_GO:      if (long_done || (min_done && minor_car)) phase_d = PH_MAJ_CAUTION;
      PH_MAJ_CAUTION: if (yel_done)   phase_d = PH_MIN_GO;
      PH_MIN_GO:      if (mingo_done) phase_d = PH_MIN_CAUTION;
      PH_MIN_CAUTION: if (yel_done)   phase_d = PH_MAJ_GO;
      default:        phase_d = PH_MAJ_GO;
    endcase
  end

  assign leave = (phase_d != phase_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_MAJ_GO;
    end else begin
      phase_q <= phase_d;
    end
  end

  assert_ring_from_maj_go_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_MAJ_GO) |=> (phase_q == PH_MAJ_GO || phase_q == PH_MAJ_CAUTION));
  assert_ring_from_maj_caution_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_MAJ_CAUTION) |=> (phase_q == PH_MAJ_CAUTION || phase_q == PH_MIN_GO));
  assert_ring_from_min_go_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_MIN_GO) |=> (phase_q == PH_MIN_GO || phase_q == PH_MIN_CAUTION));
  assert_ring_from_min_caution_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_MIN_CAUTION) |=> (phase_q == PH_MIN_CAUTION || phase_q == PH_MAJ_GO));

  assert_long_limit_exit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_MAJ_GO && long_done) |=> (phase_q == PH_MAJ_CAUTION));
  assert_early_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_MAJ_GO && min_done && minor_car) |=> (phase_q == PH_MAJ_CAUTION));
  assert_no_early_before_min_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_MAJ_GO && !min_done && !long_done) |=> (phase_q == PH_MAJ_GO));
  assert_min_go_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_MIN_GO && !mingo_done) |=> (phase_q == PH_MIN_GO));
  assert_caution_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase_q == PH_MAJ_CAUTION || phase_q == PH_MIN_CAUTION) && !yel_done) |=> $stable(phase_q));

endmodule

// File: rtl/junction_lamp_drive.sv
module junction_lamp_drive
  import junction_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  phase_e phase_q,
  output lamp_t  maj_lamp,
  output lamp_t  min_lamp
);
  always_comb begin
    maj_lamp = '{red: 1'b1, yel: 1'b0, grn: 1'b0};
    min_lamp = '{red: 1'b1, yel: 1'b0, grn: 1'b0};
    unique case (phase_q)
      PH_MAJ_GO:      maj_lamp = '{red: 1'b0, yel: 1'b0, grn: 1'b1};
      PH_MAJ_CAUTION: maj_lamp = '{red: 1'b0, yel: 1'b1, grn: 1'b0};
      PH_MIN_GO:      min_lamp = '{red: 1'b0, yel: 1'b0, grn: 1'b1};
      PH_MIN_CAUTION: min_lamp = '{red: 1'b0, yel: 1'b1, grn: 1'b0};
      default: ;
    endcase
  end

  assert_major_one_lamp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(maj_lamp) == 1);
  assert_minor_one_lamp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(min_lamp) == 1);
  assert_cross_red_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!maj_lamp.red |-> min_lamp.red) and (!min_lamp.red |-> maj_lamp.red));

endmodule

// File: rtl/junction_signal_ctrl.sv
module junction_signal_ctrl
  import junction_pkg::*;
#(
  parameter int unsigned P_MAJ_LONG = 12,
  parameter int unsigned P_MAJ_MIN  = 4,
  parameter int unsigned P_MIN_GO   = 6,
  parameter int unsigned P_CAUTION  = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic major_car,
  input  logic minor_car,
  output logic maj_red,
  output logic maj_yel,
  output logic maj_grn,
  output logic min_red,
  output logic min_yel,
  output logic min_grn
);
  localparam int unsigned LIMS [NUM_TIMERS] = '{P_MAJ_LONG, P_MAJ_MIN, P_MIN_GO, P_CAUTION};

  if (!(P_MAJ_MIN < P_MAJ_LONG) || P_MAJ_MIN == 0 || P_MIN_GO == 0 || P_CAUTION == 0) begin : g_bad_cfg
    $error("junction_signal_ctrl: durations must be nonzero with P_MAJ_MIN < P_MAJ_LONG");
  end

  phase_e                phase_q;
  logic                  leave;
  logic [NUM_TIMERS-1:0] run;
  logic [NUM_TIMERS-1:0] done;
  lamp_t                 maj_lamp, min_lamp;

  always_comb begin
    run            = '0;
    run[TMR_LONG]  = (phase_q == PH_MAJ_GO);
    run[TMR_MIN]   = (phase_q == PH_MAJ_GO);
    run[TMR_MINGO] = (phase_q == PH_MIN_GO);
    run[TMR_YEL]   = (phase_q == PH_MAJ_CAUTION) || (phase_q == PH_MIN_CAUTION);
  end

  for (genvar g = 0; g < NUM_TIMERS; g++) begin : g_tmr
    junction_interval_timer #(.LIMIT(LIMS[g])) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_en (tick_en),
      .run     (run[g]),
      .clr     (leave),
      .done    (done[g])
    );
  end

  junction_phase_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .minor_car  (minor_car),
    .long_done  (done[TMR_LONG]),
    .min_done   (done[TMR_MIN]),
    .mingo_done (done[TMR_MINGO]),
    .yel_done   (done[TMR_YEL]),
    .phase_q    (phase_q),
    .leave      (leave)
  );

  junction_lamp_drive u_lamp (
    .clk      (clk),
    .rst_n    (rst_n),
    .phase_q  (phase_q),
    .maj_lamp (maj_lamp),
    .min_lamp (min_lamp)
  );

  assign maj_red = maj_lamp.red;
  assign maj_yel = maj_lamp.yel;
  assign maj_grn = maj_lamp.grn;
  assign min_red = min_lamp.red;
  assign min_yel = min_lamp.yel;
  assign min_grn = min_lamp.grn;

  assert_major_car_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_MAJ_GO && major_car && !done[TMR_LONG] && !(done[TMR_MIN] && minor_car))
      |=> (phase_q == PH_MAJ_GO));

  assert_min_before_long_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done[TMR_LONG] |-> done[TMR_MIN]);

endmodule

// File: tb/junction_signal_ctrl_tb.sv
`timescale 1ns/1ps
module junction_signal_ctrl_tb;
  localparam int LONG_T = 12;
  localparam int MIN_T  = 4;
  localparam int GO_T   = 6;
  localparam int YEL_T  = 3;

  logic clk = 1'b0;
  logic rst_n, tick_en, major_car, minor_car;
  logic maj_red, maj_yel, maj_grn, min_red, min_yel, min_grn;

  always #2.5 clk = ~clk;

  junction_signal_ctrl #(
    .P_MAJ_LONG(LONG_T), .P_MAJ_MIN(MIN_T), .P_MIN_GO(GO_T), .P_CAUTION(YEL_T)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .major_car(major_car), .minor_car(minor_car),
    .maj_red(maj_red), .maj_yel(maj_yel), .maj_grn(maj_grn),
    .min_red(min_red), .min_yel(min_yel), .min_grn(min_grn)
  );

  int    total = 0;
  int    bad   = 0;
  string tag   = "R1";
  bit    finished = 0;

  int m_ph = 0;
  int m_el = 0;
  int prev_obs = -1;
  bit prev_rst = 0;

  function automatic logic [5:0] lamps_of(int ph);
    case (ph)
      0: return 6'b001_100;
      1: return 6'b010_100;
      2: return 6'b100_001;
      default: return 6'b100_010;
    endcase
  endfunction

  function automatic int decode(logic [5:0] v);
    for (int p = 0; p < 4; p++) if (v == lamps_of(p)) return p;
    return -1;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      logic [5:0] act;
      int obs;
      bit go;
      act = {maj_red, maj_yel, maj_grn, min_red, min_yel, min_grn};
      if (!rst_n) m_ph = 0;
      check(act == lamps_of(m_ph), tag, "lamps vs model", act, lamps_of(m_ph));
      check($countones(act[5:3]) == 1 && $countones(act[2:0]) == 1 &&
            (act[5] || act[2]), "R7", "lamp exclusivity", act, lamps_of(m_ph));
      obs = decode(act);
      if (rst_n && prev_rst && prev_obs >= 0 && obs != prev_obs)
        check(obs == (prev_obs + 1) % 4, "R2", "phase order", obs, (prev_obs + 1) % 4);
      prev_obs = obs;
      prev_rst = rst_n;
      if (!rst_n) begin
        m_ph = 0;
        m_el = 0;
      end else begin
        case (m_ph)
          0: go = (m_el >= LONG_T) || (m_el >= MIN_T && minor_car);
          1: go = (m_el >= YEL_T);
          2: go = (m_el >= GO_T);
          default: go = (m_el >= YEL_T);
        endcase
        if (go) begin
          m_ph = (m_ph + 1) % 4;
          m_el = 0;
        end else if (tick_en) begin
          m_el++;
        end
      end
    end
  end

  // mode 0: tick every cycle, 1: every third, 2: random
  // car modes: 0 low, 1 high, 2 random sparse, 3 keep
  task automatic run_cycles(int n, int tmode, int minor_mode, bit major_rand);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      case (tmode)
        0: tick_en = 1'b1;
        1: tick_en = (i % 3 == 0);
        default: tick_en = $urandom_range(0, 1);
      endcase
      case (minor_mode)
        0: minor_car = 1'b0;
        1: minor_car = 1'b1;
        2: minor_car = ($urandom_range(0, 5) == 0);
        default: ;
      endcase
      if (major_rand) major_car = $urandom_range(0, 1);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tick_en = 1'b0; major_car = 1'b0; minor_car = 1'b0;
    tag = "R1";
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 and R3: first major green must last the long limit with no car
    tag = "R3";
    run_cycles(70, 0, 0, 0);
    // R4: car waiting all the time, early exits at the minimum
    tag = "R4";
    run_cycles(50, 0, 1, 0);
    // R4: sparse car pulses, some before the minimum, some inside the window
    tag = "R4";
    run_cycles(150, 0, 2, 0);
    // R5 and R6: car held high across minor green and cautions
    tag = "R5";
    run_cycles(40, 0, 1, 0);
    tag = "R6";
    run_cycles(40, 0, 0, 0);
    // R8: sparse and random tick patterns
    tag = "R8";
    run_cycles(150, 1, 0, 0);
    run_cycles(200, 2, 2, 0);
    // R9: major-road presence toggles freely
    tag = "R9";
    run_cycles(120, 0, 0, 1);
    run_cycles(80, 2, 2, 1);
    // R1: reset partway through a cycle
    major_car = 1'b0;
    run_cycles(17, 0, 0, 0);
    tag = "R1";
    @(posedge clk); #1 rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    run_cycles(60, 0, 0, 0);
    @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule